// File: doc/BRIEF.md
# Bus Status Command Decoder

This block sits next to a processor whose bus runs in its multi-master configuration. In that configuration the processor does not drive read and write strobes itself. Instead it puts a 3-bit status code on its status lines. The decoder samples those lines on every clock edge. It recognises the start of a bus cycle when the status leaves the idle code, and it produces separate command strobes for memory read, memory write, I/O read, I/O write and interrupt acknowledge. It also produces an address-latch pulse, a data-buffer enable and a data-direction signal.

The cycle type is captured once, at the start of the cycle. The address-latch pulse lasts one clock. The command strobe follows on the next clock. The strobe stays active until the status lines have returned to the idle code and the ready input is high on the same edge. There is no request input: the status lines alone mark where each cycle begins and ends.

All outputs are active high. Status codes, written as the three lines from most to least significant, are:

| Code | Meaning |
|------|---------|
| 111 | idle |
| 000 | interrupt acknowledge |
| 001 | I/O read |
| 010 | I/O write |
| 011 | halt |
| 100 | instruction fetch |
| 101 | memory read |
| 110 | memory write |

Top module: `bus_cmd_decoder`

## Requirements
- R1: While `rst_n` is low, and in the idle state after reset, every output is 0. Asserting reset in the middle of a cycle clears all outputs at once.
- R2: A cycle starts at a clock edge where the previously sampled status was 111 and the present status is not 111. On the clock that follows this edge, `ale` is 1 for exactly one clock. `dir_rx` is also 1 on that clock for codes 000, 001, 100 and 101.
- R3: On the second clock after the start edge, exactly one strobe rises, chosen by the code captured at the start edge: `mem_rd` for 100 or 101, `mem_wr` for 110, `io_rd` for 001, `io_wr` for 010, `int_ack` for 000. No strobe is active while `ale` is 1.
- R4: A halt cycle (code 011) gives the one-clock `ale` pulse. It raises no strobe and no `data_en`, and `dir_rx` stays 0.
- R5: A strobe stays active until a clock edge at which the status is 111 and `ready` is 1, and it is 0 after that edge. Status 111 with `ready` low, or `ready` high with a non-idle status, keeps the strobe active.
- R6: Status changes after the start edge that do not reach 111 leave the active strobe unchanged.
- R7: `data_en` is 1 exactly while a strobe is active. `dir_rx` is 1 from the `ale` clock to the end of the cycle for codes 000, 001, 100 and 101, and 0 for writes and halt.
- R8: At most one of the five strobes is active at any time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_stat | input | 3 | Processor status code |
| ready | input | 1 | Transfer-complete indication, active high |
| ale | output | 1 | Address-latch pulse, one clock |
| mem_rd | output | 1 | Memory read strobe (also used for instruction fetch) |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | I/O read strobe |
| io_wr | output | 1 | I/O write strobe |
| int_ack | output | 1 | Interrupt acknowledge strobe |
| data_en | output | 1 | Data buffer enable |
| dir_rx | output | 1 | Data direction: 1 means data flows toward the processor |

## Verification
The bench builds the block with its package defaults: a 3-bit status code and five strobes. These are the only widths the status encoding allows, so every code can be driven exhaustively. The vector table runs each of the eight codes through a complete cycle. It also covers several hold-off cases:
- status idle but not ready;
- ready but status still active;
- a code change in the middle of a cycle.

A directed reset in the middle of a strobe then shows that the asynchronous clear works and that the decoder restarts cleanly afterwards.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int STAT_W = 3;
  localparam int N_CMD  = 5;

  typedef enum logic [STAT_W-1:0] {
    CYC_INTA = 3'b000,
    CYC_IORD = 3'b001,
    CYC_IOWR = 3'b010,
    CYC_HALT = 3'b011,
    CYC_CODE = 3'b100,
    CYC_MRD  = 3'b101,
    CYC_MWR  = 3'b110,
    CYC_IDLE = 3'b111
  } cyc_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_T1   = 2'd1,
    PH_CMD  = 2'd2
  } phase_e;

  // strobe vector bit positions
  localparam int SB_MRD  = 0;
  localparam int SB_MWR  = 1;
  localparam int SB_IORD = 2;
  localparam int SB_IOWR = 3;
  localparam int SB_INTA = 4;
endpackage

// File: rtl/bsc_stat_decode.sv
module bsc_stat_decode
  import bsc_pkg::*;
(
  input  cyc_e             cyc,
  output logic [N_CMD-1:0] strobe_sel,
  output logic             rd_dir
);
  always_comb begin
    strobe_sel = '0;
    rd_dir     = 1'b0;
    unique case (cyc)
      CYC_INTA: begin strobe_sel[SB_INTA] = 1'b1; rd_dir = 1'b1; end
      CYC_IORD: begin strobe_sel[SB_IORD] = 1'b1; rd_dir = 1'b1; end
      CYC_IOWR: strobe_sel[SB_IOWR] = 1'b1;
      CYC_CODE: begin strobe_sel[SB_MRD] = 1'b1; rd_dir = 1'b1; end
      CYC_MRD:  begin strobe_sel[SB_MRD] = 1'b1; rd_dir = 1'b1; end
      CYC_MWR:  strobe_sel[SB_MWR] = 1'b1;
      default:  ; // halt and idle: no strobe
    endcase
  end
endmodule

// File: rtl/bsc_seq.sv
module bsc_seq
  import bsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] stat,
  input  logic              ready,
  output phase_e            phase,
  output cyc_e              cyc_q
);
  logic [STAT_W-1:0] stat_q;
  phase_e            phase_d;
  logic              start;
  logic              done;

  assign start = (phase == PH_IDLE) && (stat_q == CYC_IDLE) && (stat != CYC_IDLE);
  assign done  = (stat == CYC_IDLE) && ready;

  always_comb begin
    phase_d = phase;
    unique case (phase)
      PH_IDLE: if (start) phase_d = PH_T1;
      PH_T1:   phase_d = PH_CMD;
      PH_CMD:  if (done) phase_d = PH_IDLE;
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q <= CYC_IDLE;
      phase  <= PH_IDLE;
      cyc_q  <= CYC_IDLE;
    end else begin
      stat_q <= stat;
      phase  <= phase_d;
      if (start) cyc_q <= cyc_e'(stat);
    end
  end

  // R2: a detected start always leads to the T1 phase
  a_r2_start_to_t1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (phase == PH_T1));
  // R6: the captured type does not move while a cycle is in progress
  a_r6_type_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD) |=> $stable(cyc_q));
endmodule

// File: rtl/bsc_cmd_out.sv
module bsc_cmd_out
  import bsc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  phase_e           phase,
  input  logic [N_CMD-1:0] strobe_sel,
  input  logic             rd_dir,
  output logic [N_CMD-1:0] strobe,
  output logic             ale,
  output logic             data_en,
  output logic             dir_rx
);
  logic in_cmd;
  assign in_cmd = (phase == PH_CMD);

  for (genvar g = 0; g < N_CMD; g++) begin : g_strobe
    assign strobe[g] = in_cmd & strobe_sel[g];
  end

  assign ale     = (phase == PH_T1);
  assign data_en = in_cmd & (|strobe_sel);
  assign dir_rx  = (phase != PH_IDLE) & rd_dir;

  // R8: strobes are mutually exclusive
  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(strobe));
  // R2: address-latch pulse lasts one clock
  a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale);
endmodule

// File: rtl/bus_cmd_decoder.sv
module bus_cmd_decoder
  import bsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [STAT_W-1:0] bus_stat,
  input  logic              ready,
  output logic              ale,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic              io_rd,
  output logic              io_wr,
  output logic              int_ack,
  output logic              data_en,
  output logic              dir_rx
);
  phase_e           phase;
  cyc_e             cyc_q;
  logic [N_CMD-1:0] strobe_sel;
  logic [N_CMD-1:0] strobe;
  logic             rd_dir;

  bsc_seq i_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .stat  (bus_stat),
    .ready (ready),
    .phase (phase),
    .cyc_q (cyc_q)
  );

  bsc_stat_decode i_dec (
    .cyc        (cyc_q),
    .strobe_sel (strobe_sel),
    .rd_dir     (rd_dir)
  );

  bsc_cmd_out i_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .phase      (phase),
    .strobe_sel (strobe_sel),
    .rd_dir     (rd_dir),
    .strobe     (strobe),
    .ale        (ale),
    .data_en    (data_en),
    .dir_rx     (dir_rx)
  );

  assign mem_rd  = strobe[SB_MRD];
  assign mem_wr  = strobe[SB_MWR];
  assign io_rd   = strobe[SB_IORD];
  assign io_wr   = strobe[SB_IOWR];
  assign int_ack = strobe[SB_INTA];

  // R5: a strobe holds until idle status and ready coincide
  a_r5_hold_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ((|strobe) && !((bus_stat == CYC_IDLE) && ready)) |=> $stable(strobe));
  // R3: a strobe only rises right after the address-latch pulse
  a_r3_strobe_after_ale: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(|strobe) |-> $past(ale));
  // R7: buffer enable tracks strobe activity
  a_r7_den_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    data_en == (|strobe));
endmodule

// File: tb/test_bus_cmd_decoder.sv
`timescale 1ns/1ps
module test_bus_cmd_decoder;
  localparam int NV = 30;
  // {stat[2:0], ready, req id[3:0], expected {ale,mrd,mwr,iord,iowr,inta,den,dir}}
  localparam logic [15:0] VEC [0:NV-1] = '{
    {3'b111,1'b1,4'd1,8'b0000_0000},
    {3'b101,1'b1,4'd2,8'b1000_0001},
    {3'b101,1'b1,4'd3,8'b0100_0011},
    {3'b111,1'b0,4'd5,8'b0100_0011},
    {3'b111,1'b1,4'd5,8'b0000_0000},
    {3'b110,1'b0,4'd2,8'b1000_0000},
    {3'b110,1'b0,4'd7,8'b0010_0010},
    {3'b110,1'b1,4'd5,8'b0010_0010},
    {3'b111,1'b1,4'd5,8'b0000_0000},
    {3'b001,1'b1,4'd2,8'b1000_0001},
    {3'b001,1'b1,4'd7,8'b0001_0011},
    {3'b111,1'b1,4'd5,8'b0000_0000},
    {3'b010,1'b1,4'd2,8'b1000_0000},
    {3'b111,1'b1,4'd3,8'b0000_1010},
    {3'b111,1'b1,4'd5,8'b0000_0000},
    {3'b000,1'b1,4'd2,8'b1000_0001},
    {3'b000,1'b1,4'd3,8'b0000_0111},
    {3'b111,1'b1,4'd5,8'b0000_0000},
    {3'b100,1'b1,4'd2,8'b1000_0001},
    {3'b100,1'b1,4'd7,8'b0100_0011},
    {3'b111,1'b1,4'd5,8'b0000_0000},
    {3'b011,1'b1,4'd4,8'b1000_0000},
    {3'b011,1'b1,4'd4,8'b0000_0000},
    {3'b111,1'b1,4'd4,8'b0000_0000},
    {3'b101,1'b1,4'd2,8'b1000_0001},
    {3'b110,1'b1,4'd6,8'b0100_0011},
    {3'b001,1'b1,4'd6,8'b0100_0011},
    {3'b111,1'b0,4'd6,8'b0100_0011},
    {3'b111,1'b1,4'd5,8'b0000_0000},
    {3'b111,1'b1,4'd1,8'b0000_0000}
  };

  logic       clk;
  logic       rst_n;
  logic [2:0] bus_stat;
  logic       ready;
  logic       ale, mem_rd, mem_wr, io_rd, io_wr, int_ack, data_en, dir_rx;
  logic [7:0] obs;
  int checks;
  int failures;

  bus_cmd_decoder i_bus_cmd_decoder (
    .clk(clk), .rst_n(rst_n), .bus_stat(bus_stat), .ready(ready),
    .ale(ale), .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd),
    .io_wr(io_wr), .int_ack(int_ack), .data_en(data_en), .dir_rx(dir_rx)
  );

  assign obs = {ale, mem_rd, mem_wr, io_rd, io_wr, int_ack, data_en, dir_rx};

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic string tag(input logic [3:0] id);
    case (id)
      4'd1: return "R1";
      4'd2: return "R2";
      4'd3: return "R3";
      4'd4: return "R4";
      4'd5: return "R5";
      4'd6: return "R6";
      4'd7: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    checks = 0;
    failures = 0;
    rst_n = 1'b0;
    bus_stat = 3'b111;
    ready = 1'b1;
    repeat (3) @(negedge clk);
    check("R1", obs, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      bus_stat = VEC[i][15:13];
      ready    = VEC[i][12];
      @(negedge clk);
      check(tag(VEC[i][11:8]), obs, VEC[i][7:0]);
      // R8: never more than one strobe
      check("R8", {7'd0, ($countones(obs[6:2]) > 1)}, 8'h00);
    end
    // R1: reset in the middle of an active strobe
    bus_stat = 3'b101;
    @(negedge clk);
    @(negedge clk);
    check("R1", obs, 8'b0100_0011);
    #2 rst_n = 1'b0;
    #1 check("R1", obs, 8'h00);
    bus_stat = 3'b111;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", obs, 8'h00);
    // restart after reset: R2
    bus_stat = 3'b110;
    @(negedge clk);
    check("R2", obs, 8'b1000_0000);
    bus_stat = 3'b111;
    ready = 1'b1;
    @(negedge clk);
    check("R3", obs, 8'b0010_0010);
    @(negedge clk);
    check("R5", obs, 8'h00);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule